// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block lets a clocked host read and write an external asynchronous static RAM of 256K words by 16 bits. The RAM has one select for each of its two byte lanes. The host side is a single-request handshake. The host presents a request flag, a write flag, an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The block accepts the request when its ready output is high. For a read, it returns the data later with a one-cycle response pulse. Requests are served one at a time, in order.

On the memory side the controller drives the active-low chip select, output enable and write enable, and one active-low strobe per byte lane. It also drives the word address and the write data. It gives a separate drive-enable for the data pins, so that a pad-level tristate can be built around it. Every timing window is a whole number of clock cycles. Each window is computed at elaboration from a nanosecond minimum and the clock period.

Between operations the memory is deselected and no lane strobe is active. A read that is followed by a write gets a bus turnaround gap. A request whose lane mask is zero completes without touching the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever no operation is in progress, chip select, output enable, write enable and both lane strobes are high. The data drive-enable is low.
- R2: A read holds chip select and output enable low, and write enable high, for RD_CYC cycles. The data pins are sampled at the clock edge that ends the last of these cycles. The response pulse follows RD_CYC+1 cycles after the accepting edge. Lane strobe bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. A strobe is low only for a set bit of the lane mask. A lane that is not selected returns zero.
- R3: A write drives the address, the lane strobes and the data for one cycle with write enable high. It then holds write enable low for WR_CYC cycles, and keeps one more cycle with write enable high and chip select still low. The data drive-enable stays high in all of these cycles. Two writes in a row are separated by exactly one deselected cycle.
- R4: While chip select is low, the address, the lane strobes and the driven data stay constant. The address equals the accepted request address.
- R5: Write enable is low only while chip select is low and output enable is high. The data drive-enable is never high while output enable is low.
- R6: When a write follows a read, TURN_CYC+1 cycles separate the end of the read from the start of the write. In these cycles chip select and output enable are high and the drive-enable is low.
- R7: A request with a zero lane mask never pulls chip select low. It leaves memory contents unchanged. For a read it gives a response of zero one cycle after the accepting edge.
- R8: Ready is high only when no operation is in progress. A request is accepted on a clock edge where both the request flag and ready are high.
- R9: RD_CYC is the ceiling of the access time over the clock period. WR_CYC is the largest of the ceilings for the write pulse and the data setup. It also covers the address-to-end window minus one cycle and the write cycle minus two cycles. TURN_CYC is the ceiling of the output turn-off time. Each is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lane_n | output | 2 | Lane strobes, active low, bit 0 lower byte |
| mem_addr | output | 18 | Memory word address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_drive | output | 1 | Drive-enable for the data pins |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench uses the default parameters: an 8 ns clock with 55, 45, 25, 50, 55 and 20 ns minimums. These give RD_CYC=7, WR_CYC=6 and TURN_CYC=3, so every window spans several cycles. A count that is off by one then changes both the measured run lengths and the data returned. The bench's memory model returns garbage until a read has been selected for RD_CYC cycles. It drives non-zero patterns on unselected lanes. It rejects short write pulses and contention on the bus. Narrow addresses in random traffic force frequent reuse of the same words. This brings read-after-partial-write merging, read-to-write turnaround and zero-mask requests into frequent reach.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } ctrl_state_t;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sub_floor(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned a);
    return (a == 0) ? 1 : a;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     deselect,
  input  logic [LANES-1:0]         mask,
  input  logic [LANES*LANE_W-1:0]  rd_raw,
  output logic [LANES-1:0]         strb_n,
  output logic [LANES*LANE_W-1:0]  rd_masked
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb_n[g] = deselect | ~mask[g];
    assign rd_masked[g*LANE_W +: LANE_W] =
      mask[g] ? rd_raw[g*LANE_W +: LANE_W] : {LANE_W{1'b0}};
  end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WR_CYC   = 6,
  parameter int unsigned TURN_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_none,
  input  logic             timer_done,
  output ctrl_state_t      state_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             timer_load_o,
  output logic [CNT_W-1:0] timer_val_o,
  output logic             rd_sample_o,
  output logic             nop_rd_o
);

  ctrl_state_t state_q;
  ctrl_state_t state_d;
  logic        last_rd_q;
  logic        last_rd_d;
  logic        last_rd_en;

  always_comb begin
    state_d      = state_q;
    ready_o      = 1'b0;
    accept_o     = 1'b0;
    timer_load_o = 1'b0;
    timer_val_o  = '0;
    rd_sample_o  = 1'b0;
    nop_rd_o     = 1'b0;
    last_rd_en   = 1'b0;
    last_rd_d    = last_rd_q;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = 1'b1;
        if (req_valid) begin
          accept_o = 1'b1;
          if (req_none) begin
            nop_rd_o = !req_write;
          end else if (req_write) begin
            if (last_rd_q) begin
              state_d      = ST_TURN;
              timer_load_o = 1'b1;
              timer_val_o  = CNT_W'(TURN_CYC - 1);
            end else begin
              state_d = ST_WSETUP;
            end
          end else begin
            state_d      = ST_READ;
            timer_load_o = 1'b1;
            timer_val_o  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (timer_done) begin
          state_d = ST_WSETUP;
        end
      end
      ST_WSETUP: begin
        state_d      = ST_WPULSE;
        timer_load_o = 1'b1;
        timer_val_o  = CNT_W'(WR_CYC - 1);
        last_rd_en   = 1'b1;
        last_rd_d    = 1'b0;
      end
      ST_WPULSE: begin
        if (timer_done) begin
          state_d = ST_WREC;
        end
      end
      ST_WREC: begin
        state_d = ST_IDLE;
      end
      ST_READ: begin
        if (timer_done) begin
          state_d     = ST_IDLE;
          rd_sample_o = 1'b1;
          last_rd_en  = 1'b1;
          last_rd_d   = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd_q <= 1'b0;
    end else if (last_rd_en) begin
      last_rd_q <= last_rd_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned LANES   = 2,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned CLK_NS  = 8,
  parameter int unsigned RD_NS   = 55,
  parameter int unsigned WP_NS   = 45,
  parameter int unsigned DW_NS   = 25,
  parameter int unsigned AW_NS   = 50,
  parameter int unsigned WC_NS   = 55,
  parameter int unsigned TURN_NS = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic [LANES-1:0]         req_mask,
  output logic                     rsp_valid,
  output logic [LANES*LANE_W-1:0]  rsp_rdata,
  output logic                     mem_cs_n,
  output logic                     mem_oe_n,
  output logic                     mem_we_n,
  output logic [LANES-1:0]         mem_lane_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic                     mem_dq_drive,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in
);

  localparam int unsigned DATA_W   = LANES * LANE_W;
  localparam int unsigned RD_CYC   = at_least_one(ns_to_cyc(RD_NS, CLK_NS));
  localparam int unsigned WR_CYC   = at_least_one(
    max2(max2(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DW_NS, CLK_NS)),
         max2(sub_floor(ns_to_cyc(AW_NS, CLK_NS), 1),
              sub_floor(ns_to_cyc(WC_NS, CLK_NS), 2))));
  localparam int unsigned TURN_CYC = at_least_one(ns_to_cyc(TURN_NS, CLK_NS));
  localparam int unsigned CNT_W    = $clog2(max2(max2(RD_CYC, WR_CYC), TURN_CYC) + 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  ctrl_state_t       state;
  logic              accept;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic              timer_done;
  logic              rd_sample;
  logic              nop_rd;
  logic              req_none;
  logic              bus_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] rd_masked;
  logic              rsp_en;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign req_none = ~|req_mask;

  sram_seq #(
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_none     (req_none),
    .timer_done   (timer_done),
    .state_o      (state),
    .ready_o      (req_ready),
    .accept_o     (accept),
    .timer_load_o (timer_load),
    .timer_val_o  (timer_val),
    .rd_sample_o  (rd_sample),
    .nop_rd_o     (nop_rd)
  );

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (timer_done)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_comb begin
    bus_sel      = (state == ST_READ) || (state == ST_WSETUP) ||
                   (state == ST_WPULSE) || (state == ST_WREC);
    mem_cs_n     = ~bus_sel;
    mem_oe_n     = (state != ST_READ);
    mem_we_n     = (state != ST_WPULSE);
    mem_dq_drive = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WREC);
  end

  sram_lane_map #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_lanes (
    .deselect  (~bus_sel),
    .mask      (mask_q),
    .rd_raw    (mem_dq_in),
    .strb_n    (mem_lane_n),
    .rd_masked (rd_masked)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  always_comb begin
    rsp_en  = rd_sample | nop_rd;
    rdata_d = rd_sample ? rd_masked : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rsp_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned LANES    = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned WR_CYC   = 6,
  parameter int unsigned TURN_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_drive,
  input logic              rsp_valid
);

  logic [7:0] we_low_cnt;
  logic [7:0] quiet_cnt;
  logic       rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
    end else if (mem_we_n) begin
      we_low_cnt <= '0;
    end else if (we_low_cnt != 8'hff) begin
      we_low_cnt <= we_low_cnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      rd_seen   <= 1'b0;
    end else if (!mem_oe_n) begin
      quiet_cnt <= '0;
      rd_seen   <= 1'b1;
    end else if (mem_dq_drive) begin
      rd_seen   <= 1'b0;
    end else if (quiet_cnt != 8'hff) begin
      quiet_cnt <= quiet_cnt + 8'd1;
    end
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && (&mem_lane_n) && !mem_dq_drive));

  // R5
  we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_drive));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_drive |-> mem_oe_n);

  // R3
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  // R3
  we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && (we_low_cnt >= WR_CYC)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_lane_n)));

  // R4
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_drive && $past(mem_dq_drive)) |-> $stable(mem_dq_out));

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_dq_drive) && rd_seen) |-> (quiet_cnt >= TURN_CYC));

  // R7
  lane_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !(&mem_lane_n));

  // R2
  rsp_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_cs_n);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .LANES    (LANES),
  .DATA_W   (DATA_W),
  .WR_CYC   (WR_CYC),
  .TURN_CYC (TURN_CYC)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mem_cs_n     (mem_cs_n),
  .mem_oe_n     (mem_oe_n),
  .mem_we_n     (mem_we_n),
  .mem_lane_n   (mem_lane_n),
  .mem_addr     (mem_addr),
  .mem_dq_out   (mem_dq_out),
  .mem_dq_drive (mem_dq_drive),
  .rsp_valid    (rsp_valid)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int CLK_NS   = 8;
  localparam int RD_CYC   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC   = (45 + CLK_NS - 1) / CLK_NS;
  localparam int TURN_CYC = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [1:0]  mem_lane_n;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_drive;
  logic [15:0] mem_dq_in;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_mask     (req_mask),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .mem_cs_n     (mem_cs_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_lane_n   (mem_lane_n),
    .mem_addr     (mem_addr),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_drive (mem_dq_drive),
    .mem_dq_in    (mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mdl_mem [256];
  logic [15:0] ref_mem [256];
  int   rd_age, wlow, err_w, err_c, err_t, quiet;
  logic after_rd;
  logic [15:0] wd;
  logic [1:0]  wl;
  logic [7:0]  wa;
  logic        rd_cond;

  assign rd_cond   = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (rd_cond && rd_age >= RD_CYC - 1) ?
    {mem_lane_n[1] ? 8'hA5 : mdl_mem[mem_addr[7:0]][15:8],
     mem_lane_n[0] ? 8'h5A : mdl_mem[mem_addr[7:0]][7:0]} : 16'hC3C3;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rd_age <= 0; wlow <= 0; after_rd <= 1'b0; quiet <= 0;
    end else begin
      rd_age <= rd_cond ? rd_age + 1 : 0;
      if (mem_dq_drive && !mem_oe_n) err_c <= err_c + 1;
      if (!mem_cs_n && !mem_we_n) begin
        wlow <= wlow + 1;
        wd   <= mem_dq_out;
        wl   <= ~mem_lane_n;
        wa   <= mem_addr[7:0];
        if (!mem_dq_drive) err_w <= err_w + 1;
      end else begin
        if (wlow != 0) begin
          if (wlow < WR_CYC) err_w <= err_w + 1;
          if (wl[0]) mdl_mem[wa][7:0]  <= wd[7:0];
          if (wl[1]) mdl_mem[wa][15:8] <= wd[15:8];
        end
        wlow <= 0;
      end
      if (!mem_oe_n) begin
        quiet <= 0; after_rd <= 1'b1;
      end else if (mem_dq_drive) begin
        if (after_rd && quiet < TURN_CYC) err_t <= err_t + 1;
        after_rd <= 1'b0;
      end else begin
        quiet <= quiet + 1;
      end
    end
  end

  // ---------------- monitor ----------------
  logic [15:0] exp_dat_q [$];
  int          exp_lat_q [$];
  int          acc_cyc_q [$];
  logic [17:0] cur_addr;
  int ce_low_run, ce_hi_run, last_ce_run, last_gap, we_run, last_we_run, ce_falls;
  logic prev_ce, prev_we;
  logic [1:0] last_strb;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_dat_q.size() == 0) begin
          chk("R2 unexpected response", 32'd1, 32'd0);
        end else begin
          automatic logic [15:0] ed = exp_dat_q.pop_front();
          automatic int el = exp_lat_q.pop_front();
          automatic int ac = acc_cyc_q.pop_front();
          chk(el == 1 ? "R7 zero-mask read data" : "R2 read data", rsp_rdata, ed);
          chk(el == 1 ? "R7 zero-mask latency" : "R2 R9 read latency", cyc - ac, el);
        end
      end
      if (!mem_cs_n) begin
        if (prev_ce) begin
          last_gap = ce_hi_run;
          ce_falls++;
          chk("R4 address at select", mem_addr, cur_addr);
        end
        ce_low_run++; ce_hi_run = 0; last_strb = mem_lane_n;
      end else begin
        if (!prev_ce) last_ce_run = ce_low_run;
        ce_low_run = 0; ce_hi_run++;
      end
      if (!mem_we_n) we_run++;
      else begin
        if (!prev_we) last_we_run = we_run;
        we_run = 0;
      end
      prev_ce = mem_cs_n;
      prev_we = mem_we_n;
    end
  end

  task automatic issue(input logic w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    cur_addr = a;
    if (w) begin
      if (m[0]) ref_mem[a[7:0]][7:0]  = d[7:0];
      if (m[1]) ref_mem[a[7:0]][15:8] = d[15:8];
    end else begin
      exp_dat_q.push_back({m[1] ? ref_mem[a[7:0]][15:8] : 8'h00,
                           m[0] ? ref_mem[a[7:0]][7:0]  : 8'h00});
      exp_lat_q.push_back(m == 2'b00 ? 1 : RD_CYC + 1);
      acc_cyc_q.push_back(cyc);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || exp_dat_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog expired actual 1 expected 0");
    report();
    $finish;
  end

  initial begin
    int falls0;
    logic [31:0] t;
    for (int i = 0; i < 256; i++) begin
      mdl_mem[i] = 16'h0000; ref_mem[i] = 16'h0000;
    end
    err_w = 0; err_c = 0; err_t = 0;
    ce_low_run = 0; ce_hi_run = 0; last_ce_run = 0; last_gap = 0;
    we_run = 0; last_we_run = 0; ce_falls = 0;
    prev_ce = 1'b1; prev_we = 1'b1; last_strb = 2'b11; cur_addr = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n in reset", mem_cs_n, 1);
    chk("R1 we_n in reset", mem_we_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs_n idle", mem_cs_n, 1);
    chk("R1 oe_n idle", mem_oe_n, 1);
    chk("R1 we_n idle", mem_we_n, 1);
    chk("R1 lane strobes idle", mem_lane_n, 2'b11);
    chk("R1 drive idle", mem_dq_drive, 0);
    chk("R8 ready idle", req_ready, 1);
    chk("R1 no response idle", rsp_valid, 0);

    // full word write then read
    issue(1'b1, 18'h3_0005, 16'h1234, 2'b11);
    @(negedge clk);
    chk("R8 ready low while busy", req_ready, 0);
    wait_idle();
    chk("R3 R9 write pulse cycles", last_we_run, WR_CYC);
    chk("R3 write select cycles", last_ce_run, WR_CYC + 2);
    issue(1'b0, 18'h3_0005, 16'h0, 2'b11);
    wait_idle();
    chk("R2 R9 read select cycles", last_ce_run, RD_CYC);

    // read then write back to back: turnaround
    issue(1'b0, 18'h0_0005, 16'h0, 2'b11);
    issue(1'b1, 18'h0_0106, 16'hBEEF, 2'b11);
    wait_idle();
    chk("R6 read-to-write gap", last_gap, TURN_CYC + 1);

    // write then write back to back
    issue(1'b1, 18'h0_0107, 16'h0F0F, 2'b11);
    issue(1'b1, 18'h0_0108, 16'hF0F0, 2'b11);
    wait_idle();
    chk("R3 write-to-write gap", last_gap, 1);

    // lane writes and masked reads
    issue(1'b1, 18'h0_0005, 16'hAA77, 2'b01);
    issue(1'b1, 18'h0_0005, 16'h99BB, 2'b10);
    issue(1'b0, 18'h0_0005, 16'h0, 2'b11);
    issue(1'b0, 18'h0_0005, 16'h0, 2'b01);
    wait_idle();
    chk("R2 lower lane strobe", last_strb, 2'b10);
    issue(1'b0, 18'h2_0005, 16'h0, 2'b10);
    wait_idle();
    chk("R2 upper lane strobe", last_strb, 2'b01);

    // zero mask
    falls0 = ce_falls;
    issue(1'b1, 18'h0_0005, 16'hFFFF, 2'b00);
    issue(1'b0, 18'h0_0005, 16'h0, 2'b00);
    wait_idle();
    chk("R7 no select on zero mask", ce_falls, falls0);
    issue(1'b0, 18'h0_0005, 16'h0, 2'b11);
    wait_idle();

    // constrained random traffic
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      t = $urandom();
      issue(t[31], {t[17:8], 3'b000, t[4:0]}, $urandom(), t[29:28]);
      if (t[27:25] == 3'd0) repeat (int'(t[24:23])) @(negedge clk);
    end
    wait_idle();
    chk("R2 all responses returned", exp_dat_q.size(), 0);
    chk("R3 model write pulse errors", err_w, 0);
    chk("R5 model contention errors", err_c, 0);
    chk("R6 model turnaround errors", err_t, 0);
    report();
    $finish;
  end

endmodule